// File: doc/BRIEF.md
# Pin Event Interrupt Detector

This block watches a group of general-purpose input pins and turns selected pin activity into interrupt or DMA requests. Each pin carries a 4-bit event code. The code picks the kind of activity that counts as an event: a rising edge, a falling edge, either edge, a low level or a high level. It also picks where the event is routed, to the interrupt line or to the DMA request line. Detection runs no matter which function the pin is muxed to.

Each pin input first passes through a two-flop synchroniser. Edges are found by comparing the synchronised value with its value one cycle earlier. A detected event sets a sticky per-pin flag. Software clears flags by writing ones through a mask strobe; zero bits in the mask leave their flags alone. For a pin routed to DMA, a per-pin transfer-complete strobe also clears the flag. When an event and a clear land in the same cycle, the event wins. While a level-mode pin still holds its level, its flag cannot be cleared.

The interrupt output is the OR of the flags of all interrupt-routed pins. The DMA request output is the OR of the flags of all DMA-routed pins. The flags are also visible as a status word.

Top module: `pin_event_detect`

## Requirements
- R1: After reset all flags, `irq` and `dma_req` are 0, and every pin's code is 0000 (disabled).
- R2: Codes 0000, 0100 and every code not listed in R3 to R5 (for example 0111) never set the pin's flag, whatever the pin does.
- R3: Codes 0001, 0010 and 0011 set the flag on a rising, falling or either edge respectively; such a flag drives `dma_req` and not `irq`.
- R4: Codes 1001, 1010 and 1011 set the flag on a rising, falling or either edge respectively; such a flag drives `irq` and not `dma_req`.
- R5: Code 1000 sets the flag while the synchronised pin is 0, and code 1100 sets it while the pin is 1; both route to `irq`.
- R6: A pin change that meets the clock before edge E0 is first seen in `status` after edge E0+2 (two synchroniser stages and the flag register), and not after edge E0+1.
- R7: A flag stays set until cleared; a cycle with `clr_we` high clears exactly the flags whose `clr_mask` bit is 1, and zero bits have no effect.
- R8: A `dma_done` pulse clears the flag of a pin with a DMA code (0001 to 0011), and has no effect on a pin with an interrupt code.
- R9: For a level code, a clear issued while the pin still holds the level leaves the flag set.
- R10: When a pin's event and a clear of that pin fall in the same cycle, the flag is 1 after that edge.
- R11: `irq` is the OR of the flags of pins with interrupt codes, and `dma_req` is the OR of the flags of pins with DMA codes; pins act independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPINS | Asynchronous pin levels |
| cfg_we | input | 1 | Write strobe for one pin's event code |
| cfg_sel | input | $clog2(NPINS) | Pin index for the code write |
| cfg_code | input | 4 | Event code to write |
| clr_we | input | 1 | Write-one-to-clear strobe for the flags |
| clr_mask | input | NPINS | Flags to clear (1 = clear) |
| dma_done | input | NPINS | Per-pin DMA transfer-complete strobe |
| status | output | NPINS | Per-pin sticky event flags |
| irq | output | 1 | OR of the flags of interrupt-routed pins |
| dma_req | output | 1 | OR of the flags of DMA-routed pins |

## Verification
On every cycle the assertions check the flag rules. A disabled pin's flag stays low, and a flag holds unless a matching clear arrives. A DMA completion drops a DMA pin's flag when no new event is present, a detected event always leaves the flag set, and no flag means both request lines are quiet. The exact three-edge latency, the coding of each event kind, the per-pin routing to the two request lines, and the level-holding behaviour during a clear only show up in the bench's scenarios. Those scenarios are directed sequences plus a seeded random run compared against a cycle model.

// File: rtl/pin_event_detect.sv
module pin_event_detect #(
  parameter int NPINS = 8,
  localparam int SELW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic             cfg_we,
  input  logic [SELW-1:0]  cfg_sel,
  input  logic [3:0]       cfg_code,
  input  logic             clr_we,
  input  logic [NPINS-1:0] clr_mask,
  input  logic [NPINS-1:0] dma_done,
  output logic [NPINS-1:0] status,
  output logic             irq,
  output logic             dma_req
);

  logic [NPINS-1:0] sync1_q, sync2_q, prev_q, flag_q;
  logic [NPINS-1:0] evt, irq_mode, dma_mode;
  logic [3:0]       code_q [NPINS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, clr;

    assign rise = sync2_q[i] & ~prev_q[i];
    assign fall = ~sync2_q[i] & prev_q[i];
    assign dma_mode[i] = (code_q[i][3:2] == 2'b00) && (code_q[i][1:0] != 2'b00);
    assign irq_mode[i] = (code_q[i][3:2] == 2'b10) || (code_q[i] == 4'b1100);
    assign clr = (clr_we & clr_mask[i]) | (dma_done[i] & dma_mode[i]);

    always_comb begin
      unique case (code_q[i])
        4'b0001, 4'b1001: evt[i] = rise;
        4'b0010, 4'b1010: evt[i] = fall;
        4'b0011, 4'b1011: evt[i] = rise | fall;
        4'b1000:          evt[i] = ~sync2_q[i];
        4'b1100:          evt[i] = sync2_q[i];
        default:          evt[i] = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        code_q[i] <= 4'b0000;
        flag_q[i] <= 1'b0;
      end else begin
        if (cfg_we && cfg_sel == SELW'(i)) code_q[i] <= cfg_code;
        flag_q[i] <= evt[i] | (flag_q[i] & ~clr);
      end
    end
  end

  assign status  = flag_q;
  assign irq     = |(flag_q & irq_mode);
  assign dma_req = |(flag_q & dma_mode);

endmodule

// File: rtl/pin_event_detect_chk.sv
module pin_event_detect_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] status,
  input logic             irq,
  input logic             dma_req,
  input logic             clr_we,
  input logic [NPINS-1:0] clr_mask,
  input logic [NPINS-1:0] dma_done,
  input logic [NPINS-1:0] evt,
  input logic [NPINS-1:0] irq_mode,
  input logic [NPINS-1:0] dma_mode
);

  assert_idle_lines_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> (!irq && !dma_req));

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    assert_off_pin_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!status[i] && !irq_mode[i] && !dma_mode[i]) |=> !status[i]);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !(clr_we && clr_mask[i]) && !(dma_done[i] && dma_mode[i])) |=> status[i]);

    assert_dma_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && dma_mode[i] && dma_done[i] && !evt[i]) |=> !status[i]);

    assert_event_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> status[i]);
  end

endmodule

bind pin_event_detect pin_event_detect_chk #(.NPINS(NPINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .status   (status),
  .irq      (irq),
  .dma_req  (dma_req),
  .clr_we   (clr_we),
  .clr_mask (clr_mask),
  .dma_done (dma_done),
  .evt      (evt),
  .irq_mode (irq_mode),
  .dma_mode (dma_mode)
);

// File: tb/pin_event_detect_bench.sv
`timescale 1ns/1ps
module pin_event_detect_bench;
  localparam int NP = 8;
  localparam int SW = $clog2(NP);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic          cfg_we = 1'b0;
  logic [SW-1:0] cfg_sel = '0;
  logic [3:0]    cfg_code = '0;
  logic          clr_we = 1'b0;
  logic [NP-1:0] clr_mask = '0;
  logic [NP-1:0] dma_done = '0;
  logic [NP-1:0] status;
  logic          irq, dma_req;

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pin_event_detect #(.NPINS(NP)) u_pin_event_detect (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_code(cfg_code), .clr_we(clr_we), .clr_mask(clr_mask), .dma_done(dma_done),
    .status(status), .irq(irq), .dma_req(dma_req));

  function automatic bit is_dma(input logic [3:0] c);
    return (c == 4'b0001) || (c == 4'b0010) || (c == 4'b0011);
  endfunction

  function automatic bit is_irq(input logic [3:0] c);
    return (c == 4'b1000) || (c == 4'b1001) || (c == 4'b1010) || (c == 4'b1011) || (c == 4'b1100);
  endfunction

  function automatic bit want(input logic [3:0] c, input logic now, input logic was);
    case (c)
      4'b0001, 4'b1001: return now && !was;
      4'b0010, 4'b1010: return !now && was;
      4'b0011, 4'b1011: return now != was;
      4'b1000:          return !now;
      4'b1100:          return now;
      default:          return 1'b0;
    endcase
  endfunction

  logic [NP-1:0] ms1, ms2, mprev, mflag;
  logic [3:0]    mcfg [NP];

  always @(posedge clk) begin
    if (!rst_n) begin
      ms1 <= '0; ms2 <= '0; mprev <= '0; mflag <= '0;
      for (int i = 0; i < NP; i++) mcfg[i] <= 4'b0000;
    end else begin
      ms1 <= pin_in; ms2 <= ms1; mprev <= ms2;
      if (cfg_we) mcfg[cfg_sel] <= cfg_code;
      for (int i = 0; i < NP; i++) begin
        mflag[i] <= want(mcfg[i], ms2[i], mprev[i]) |
                    (mflag[i] & ~((clr_we & clr_mask[i]) | (dma_done[i] & is_dma(mcfg[i]))));
      end
    end
  end

  function automatic logic m_irq();
    logic r = 1'b0;
    for (int i = 0; i < NP; i++) r |= mflag[i] & is_irq(mcfg[i]);
    return r;
  endfunction

  function automatic logic m_dma();
    logic r = 1'b0;
    for (int i = 0; i < NP; i++) r |= mflag[i] & is_dma(mcfg[i]);
    return r;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic set_code(input int p, input logic [3:0] c);
    cfg_we = 1'b1; cfg_sel = SW'(p); cfg_code = c;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic clear(input logic [NP-1:0] m);
    clr_we = 1'b1; clr_mask = m;
    tick(1);
    clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R1 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240517));
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk(status, 0, "R1 status");
    chk(irq, 0, "R1 irq");
    chk(dma_req, 0, "R1 dma_req");

    // R4/R6 interrupt rising edge on pin 0 with latency
    set_code(0, 4'b1001);
    pin_in[0] = 1'b1;
    tick(2);
    chk(status[0], 0, "R6 not yet after two edges");
    tick(1);
    chk(status[0], 1, "R6 seen after three edges");
    chk(irq, 1, "R4 irq from rise code");
    chk(dma_req, 0, "R4 no dma_req");

    // R7 zero mask has no effect, one clears
    clear('0);
    chk(status[0], 1, "R7 zero mask keeps flag");
    clear(8'h01);
    chk(status[0], 0, "R7 write one clears");
    chk(irq, 0, "R11 irq drops with flag");

    // R3 DMA rising edge on pin 1, R8 dma_done clears it
    set_code(1, 4'b0001);
    pin_in[1] = 1'b1;
    tick(3);
    chk(status, 8'h02, "R3 dma rise flag");
    chk(dma_req, 1, "R3 dma_req");
    chk(irq, 0, "R3 no irq");
    dma_done[1] = 1'b1; tick(1); dma_done[1] = 1'b0;
    chk(status[1], 0, "R8 dma_done clears dma pin");
    chk(dma_req, 0, "R11 dma_req drops");

    // R4 falling-edge interrupt on pin 2; R8 dma_done ignored
    set_code(2, 4'b1010);
    pin_in[2] = 1'b1; tick(3);
    chk(status[2], 0, "R4 fall code ignores rise");
    pin_in[2] = 1'b0; tick(3);
    chk(status[2], 1, "R4 fall code sets");
    dma_done[2] = 1'b1; tick(1); dma_done[2] = 1'b0;
    chk(status[2], 1, "R8 dma_done ignored for irq pin");
    clear(8'h04);

    // R2 reserved and unlisted codes
    set_code(3, 4'b0100);
    set_code(7, 4'b0111);
    pin_in[3] = 1'b1; pin_in[7] = 1'b1; tick(3);
    pin_in[3] = 1'b0; pin_in[7] = 1'b0; tick(3);
    chk(status[3], 0, "R2 code 0100 silent");
    chk(status[7], 0, "R2 code 0111 silent");
    chk({irq, dma_req}, 0, "R2 no requests");

    // R5/R9 low level on pin 4
    set_code(4, 4'b1000);
    tick(2);
    chk(status[4], 1, "R5 low level sets");
    clear(8'h10);
    chk(status[4], 1, "R9 clear while level held");
    pin_in[4] = 1'b1; tick(3);
    clear(8'h10);
    chk(status[4], 0, "R9 clear after level gone");

    // R5 high level on pin 5
    set_code(5, 4'b1100);
    pin_in[5] = 1'b1; tick(3);
    chk(status[5], 1, "R5 high level sets");
    chk(irq, 1, "R5 level routes to irq");
    pin_in[5] = 1'b0; tick(3);
    clear(8'h20);

    // R10 set wins over clear on pin 6 (either edge)
    set_code(6, 4'b1011);
    pin_in[6] = 1'b1; tick(3);
    chk(status[6], 1, "R4 either edge rise");
    pin_in[6] = 1'b0;
    tick(2);
    clear(8'h40);
    chk(status[6], 1, "R10 event beats clear");
    clear(8'h40);
    chk(status[6], 0, "R10 later clear works");

    // R3 either-edge DMA on pin 1 falling
    set_code(1, 4'b0011);
    pin_in[1] = 1'b0; tick(3);
    chk(status[1], 1, "R3 either edge fall");
    dma_done = 8'h02; tick(1); dma_done = '0;

    // randomized run against the cycle model (R2..R11)
    for (int n = 0; n < 4000; n++) begin
      chk(status, mflag, "R7 status vs model");
      chk(irq, m_irq(), "R11 irq vs model");
      chk(dma_req, m_dma(), "R11 dma_req vs model");
      if ($urandom_range(3) == 0) pin_in ^= NP'($urandom);
      cfg_we = ($urandom_range(7) == 0);
      cfg_sel = SW'($urandom);
      cfg_code = 4'($urandom);
      clr_we = ($urandom_range(5) == 0);
      clr_mask = NP'($urandom);
      dma_done = ($urandom_range(4) == 0) ? NP'($urandom) : '0;
      tick(1);
    end
    finish_run();
  end
endmodule